// File: doc/BRIEF.md
# Serial x16 EEPROM Instruction Front End

This block is the serial-facing engine of a word-organised EEPROM model. It watches a chip-select line, a slow serial clock and a data line, all asynchronous to the system clock. After chip select rises it waits for a leading one on the data line. It then collects a two-bit command, an eight-bit word address and, for the programming commands, sixteen-bit data words. It serves reads out of an internal 256 x 16 array. It runs single-word programming, programming of up to four words in one aligned group, and a fill of the whole array. Each of these ends in a self-timed busy period, measured in system-clock cycles.

The serial inputs and the two control pins pass through two-flop synchronisers before the engine sees them. Serial-clock and chip-select edges are found in the system-clock domain. During and after programming, raising chip select shows busy or ready on the serial output. A write-enable latch and the write-control pin gate every change to the array. The protect pin turns away any instruction decoded while it is high.

Top module: `sereep_front`

## Requirements
- R1: While chip select is high and no programming is running, zeros sampled on rising serial-clock edges are skipped; the first one sampled is taken as the start bit.
- R2: The two bits after the start bit select the command: 10 read, 01 single-word write, 11 group write, 00 extended. For 00, address bits [7:6] pick 01 fill-all, 11 enable writes, 00 disable writes.
- R3: On the rising edge that samples the last address bit of a read, the output turns on and shows 0. The next sixteen rising edges each present one bit of the addressed word, MSB first. The output changes on no other edge.
- R4: While chip select stays high, a read carries on with the next address and no leading 0. Address FFh is followed by 00h.
- R5: A write stores its sixteen data bits, MSB first, at the sent address when chip select falls after the last data bit and before the next rising serial-clock edge.
- R6: If chip select falls before the last data bit, or after one more rising edge, nothing is written.
- R7: A group write takes one to four words. Word k goes to the address whose bits [7:2] match the sent address and whose bits [1:0] are the sent low bits plus k, modulo 4.
- R8: After reset, writes are refused. The enable command allows them and the disable command refuses them again. Reads work the same in both states.
- R9: A write, group write or fill is discarded when the write-control pin is low as chip select falls.
- R10: The fill-all command writes its data word to all 256 addresses.
- R11: While programming runs, high chip select drives the output on at 0 and the serial inputs are ignored. Once programming ends, the output shows 1 until a start bit is taken or chip select falls.
- R12: The output enable is low whenever chip select is low. It is also low with chip select high when no read data and no busy/ready status is due.
- R13: After reset every word of the array holds FFFFh.
- R14: An instruction whose address completes while the protect pin is high is discarded: no read output and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_pin | input | 1 | Chip select, active high, asynchronous |
| sck_pin | input | 1 | Serial clock, asynchronous |
| sdi_pin | input | 1 | Serial data in |
| wctl_pin | input | 1 | Write-control pin; must be high for programming |
| prot_pin | input | 1 | Protect pin; high turns away instructions |
| sdo | output | 1 | Serial data out (read bits or busy/ready) |
| sdo_oe | output | 1 | Output enable for sdo |

## Verification
The bench aims at the one-edge window in which chip select must fall to commit a write. A design that counted one bit too few or too many would program on a late fall or miss an on-time one. Sequential reads cross from FFh to 00h, so a design that stopped at the top, or put a leading 0 before every word, gives a wrong second word. A group write that starts two slots below the group boundary shows whether only the low two bits wrap. A design that carried into bit 2 would change address 10h. Busy is checked while a read is being clocked in, which shows that inputs are ignored during programming. The enable latch and the protect pin are checked by reading back words they must have kept untouched.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

  typedef enum logic [2:0] {
    ST_HUNT, ST_OPC, ST_ADDR, ST_DATA, ST_ARM, ST_READ, ST_HOLD
  } fe_state_t;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_GROUP = 2'b11
  } opcode_t;

  typedef enum logic [1:0] {
    WK_WORD, WK_GROUP, WK_ALL
  } wkind_t;

  localparam logic [1:0] EXT_FILL    = 2'b01;
  localparam logic [1:0] EXT_ENABLE  = 2'b11;
  localparam logic [1:0] EXT_DISABLE = 2'b00;

endpackage

// File: rtl/sereep_pin_sync.sv
module sereep_pin_sync #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta, stab, prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= 1'b0;
        stab <= 1'b0;
        prev <= 1'b0;
      end else begin
        meta <= pins[g];
        stab <= meta;
        prev <= stab;
      end
    end
    assign lvl[g]  = stab;
    assign rise[g] = stab & ~prev;
    assign fall[g] = ~stab & prev;
  end
endmodule

// File: rtl/sereep_prog_timer.sv
module sereep_prog_timer #(
  parameter int CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int TW = $clog2(CYC + 1);
  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (start)           remain <= TW'(CYC);
    else if (remain != '0)    remain <= remain - 1'b1;
  end
  assign busy = (remain != '0);

  a_r11_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/sereep_word_array.sv
module sereep_word_array #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int GROUP = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_go,
  input  logic                      wr_all,
  input  logic [AW-1:0]             wr_base,
  input  logic [$clog2(GROUP):0]    wr_cnt,
  input  logic [GROUP-1:0][DW-1:0]  wr_words,
  input  logic [AW-1:0]             rd_addr,
  output logic [DW-1:0]             rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = $clog2(GROUP);

  logic [DW-1:0] mem [DEPTH];

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base, input int k);
    logic [PW-1:0] low;
    low = base[PW-1:0] + PW'(k);
    return {base[AW-1:PW], low};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_all) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= wr_words[0];
    end else if (wr_go) begin
      for (int k = 0; k < GROUP; k++)
        if (k < int'(wr_cnt)) mem[slot_addr(wr_base, k)] <= wr_words[k];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sereep_front.sv
module sereep_front #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int GROUP_WORDS = 4,
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_pin,
  input  logic sck_pin,
  input  logic sdi_pin,
  input  logic wctl_pin,
  input  logic prot_pin,
  output logic sdo,
  output logic sdo_oe
);
  import sereep_pkg::*;

  localparam int PW = $clog2(GROUP_WORDS);
  localparam int CW = $clog2(DATA_W);
  localparam int IX_S = 0, IX_C = 1, IX_D = 2, IX_W = 3, IX_P = 4;

  // synchronised pins and edges
  logic [4:0] p_lvl, p_rise, p_fall;
  sereep_pin_sync #(.N(5)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pins({prot_pin, wctl_pin, sdi_pin, sck_pin, cs_pin}),
    .lvl(p_lvl), .rise(p_rise), .fall(p_fall)
  );
  wire s_lvl   = p_lvl[IX_S];
  wire s_fall  = p_fall[IX_S];
  wire c_rise  = p_rise[IX_C];
  wire d_lvl   = p_lvl[IX_D];
  wire w_lvl   = p_lvl[IX_W];
  wire pre_lvl = p_lvl[IX_P];
  logic unused_edges;
  assign unused_edges = ^{p_rise[IX_S], p_rise[4:2], p_fall[4:1], p_lvl[IX_C]};

  fe_state_t                       st;
  opcode_t                         opc;
  wkind_t                          kind;
  logic [CW-1:0]                   bit_cnt;
  logic [ADDR_W-1:0]               addr;
  logic [DATA_W-1:0]               shreg;
  logic [GROUP_WORDS-1:0][DATA_W-1:0] grp_words;
  logic [PW:0]                     grp_cnt;
  logic                            commit_win, wen_q, show_rdy, rd_q, rd_oe;
  logic                            busy;
  logic [DATA_W-1:0]               rd_data;

  // arithmetic helpers
  function automatic logic [ADDR_W-1:0] next_word(input logic [ADDR_W-1:0] a);
    return ADDR_W'(a + 1'b1);
  endfunction
  function automatic logic [ADDR_W-1:0] shift_in_addr(input logic [ADDR_W-1:0] a, input logic b);
    return {a[ADDR_W-2:0], b};
  endfunction

  // named internal events
  wire addr_done = (st == ST_ADDR) && (bit_cnt == CW'(ADDR_W - 1));
  wire word_done = (st == ST_DATA) && (bit_cnt == CW'(DATA_W - 1));
  wire step      = s_lvl && !busy && c_rise;
  wire prog_start = s_fall && commit_win && wen_q && w_lvl && !busy;
  wire [ADDR_W-1:0] new_addr = shift_in_addr(addr, d_lvl);
  wire [DATA_W-1:0] word_in  = {shreg[DATA_W-2:0], d_lvl};
  wire [ADDR_W-1:0] rd_addr  = (st == ST_ADDR) ? new_addr : next_word(addr);

  sereep_word_array #(.AW(ADDR_W), .DW(DATA_W), .GROUP(GROUP_WORDS)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_go(prog_start && kind != WK_ALL),
    .wr_all(prog_start && kind == WK_ALL),
    .wr_base(addr), .wr_cnt(grp_cnt), .wr_words(grp_words),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  sereep_prog_timer #(.CYC(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_HUNT;  opc <= OP_EXT;  kind <= WK_WORD;
      bit_cnt <= '0;  addr <= '0;     shreg <= '0;
      grp_words <= '0; grp_cnt <= '0;
      commit_win <= 1'b0; wen_q <= 1'b0; show_rdy <= 1'b0;
      rd_q <= 1'b0; rd_oe <= 1'b0;
    end else if (s_fall) begin
      st <= ST_HUNT;
      commit_win <= 1'b0;
      rd_oe <= 1'b0;
      rd_q  <= 1'b0;
      if (prog_start)  show_rdy <= 1'b1;
      else if (!busy)  show_rdy <= 1'b0;
    end else if (step) begin
      commit_win <= 1'b0;
      case (st)
        ST_HUNT: if (d_lvl) begin
          st <= ST_OPC; bit_cnt <= '0; show_rdy <= 1'b0;
        end
        ST_OPC: begin
          opc <= opcode_t'({opc[0], d_lvl});
          if (bit_cnt == CW'(1)) begin st <= ST_ADDR; bit_cnt <= '0; end
          else bit_cnt <= bit_cnt + 1'b1;
        end
        ST_ADDR: begin
          addr <= new_addr;
          bit_cnt <= addr_done ? '0 : bit_cnt + 1'b1;
          grp_cnt <= '0;
          if (addr_done) begin
            if (pre_lvl) st <= ST_HOLD;
            else case (opc)
              OP_READ:  begin st <= ST_READ; shreg <= rd_data; rd_q <= 1'b0; rd_oe <= 1'b1; end
              OP_WRITE: begin st <= ST_DATA; kind <= WK_WORD; end
              OP_GROUP: begin st <= ST_DATA; kind <= WK_GROUP; end
              default: begin
                st <= ST_HOLD;
                if (new_addr[ADDR_W-1 -: 2] == EXT_FILL) begin st <= ST_DATA; kind <= WK_ALL; end
                else if (new_addr[ADDR_W-1 -: 2] == EXT_ENABLE)  wen_q <= 1'b1;
                else if (new_addr[ADDR_W-1 -: 2] == EXT_DISABLE) wen_q <= 1'b0;
              end
            endcase
          end
        end
        ST_DATA: begin
          shreg <= word_in;
          if (word_done) begin
            grp_words[grp_cnt[PW-1:0]] <= word_in;
            grp_cnt <= grp_cnt + 1'b1;
            commit_win <= 1'b1;
            bit_cnt <= '0;
            if (kind != WK_GROUP || grp_cnt == (PW+1)'(GROUP_WORDS - 1)) st <= ST_ARM;
          end else bit_cnt <= bit_cnt + 1'b1;
        end
        ST_ARM: st <= ST_HOLD;
        ST_READ: begin
          rd_q <= shreg[DATA_W-1];
          if (bit_cnt == CW'(DATA_W - 1)) begin
            shreg <= rd_data; addr <= next_word(addr); bit_cnt <= '0;
          end else begin
            shreg <= {shreg[DATA_W-2:0], 1'b0}; bit_cnt <= bit_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdo_oe = s_lvl && (busy || show_rdy || rd_oe);
  assign sdo    = sdo_oe && (busy ? 1'b0 : (show_rdy ? 1'b1 : rd_q));

  a_r1_hunt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st == ST_HUNT && !d_lvl) |=> st == ST_HUNT);
  a_r3_q_holds_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && s_lvl && !c_rise) |=> $stable(rd_q));
  a_r4_read_addr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st == ST_READ && bit_cnt == CW'(DATA_W - 1)) |=> addr == next_word($past(addr)));
  a_r11_fsm_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> st == ST_HUNT);
endmodule

// File: tb/sereep_front_bench.sv
module sereep_front_bench;
  localparam int HP   = 6;
  localparam int PROG = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_pin = 0, c_pin = 0, d_pin = 0, w_pin = 1, pre_pin = 0;
  logic q, qoe;
  int nvec = 0, nfail = 0;

  always #4 clk = ~clk;

  sereep_front #(.PROG_CYCLES(PROG)) u_sereep_front (
    .clk(clk), .rst_n(rst_n), .cs_pin(s_pin), .sck_pin(c_pin), .sdi_pin(d_pin),
    .wctl_pin(w_pin), .prot_pin(pre_pin), .sdo(q), .sdo_oe(qoe)
  );

  // op codes of the table: 0 read-and-compare, 1 write, 2 enable, 3 disable
  localparam logic [26:0] VEC [12] = '{
    {3'd0, 8'h05, 16'hFFFF}, {3'd1, 8'h05, 16'h1234}, {3'd0, 8'h05, 16'hFFFF},
    {3'd2, 8'h00, 16'h0000}, {3'd1, 8'h05, 16'h1234}, {3'd0, 8'h05, 16'h1234},
    {3'd1, 8'h06, 16'hABCD}, {3'd0, 8'h06, 16'hABCD}, {3'd3, 8'h00, 16'h0000},
    {3'd1, 8'h06, 16'h0000}, {3'd0, 8'h06, 16'hABCD}, {3'd0, 8'h05, 16'h1234}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    c_pin = 1'b0; d_pin = b;
    repeat (HP) @(negedge clk);
    c_pin = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic send(input int n, input logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) tick(v[i]);
  endtask

  task automatic sel();
    c_pin = 1'b0; s_pin = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic desel();
    c_pin = 1'b0; s_pin = 1'b0;
    repeat (2 * HP) @(negedge clk);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [7:0] a);
    send(11, {21'd0, 1'b1, op, a});
  endtask

  task automatic rd_word(output logic [15:0] w);
    w = '0;
    for (int i = 0; i < 16; i++) begin tick(1'b0); w = {w[14:0], q}; end
  endtask

  task automatic do_read(input logic [7:0] a, output logic [15:0] w);
    sel(); hdr(2'b10, a);
    chk("R3 leading 0 with output on", {14'd0, qoe, q}, 16'h0002);
    rd_word(w);
    desel();
  endtask

  task automatic settle();
    repeat (PROG + 60) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] op, input logic [7:0] a, input logic [15:0] v);
    sel(); hdr(op, a); send(16, {16'd0, v}); desel(); settle();
  endtask

  task automatic do_ext(input logic [1:0] sub);
    sel(); hdr(2'b00, {sub, 6'd0}); desel();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] w, w2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R12 output off after reset", {15'd0, qoe}, 16'h0000);

    // table walk: R13 initial data, R5 commit, R8 enable latch, R2 commands
    for (int i = 0; i < 12; i++) begin
      case (VEC[i][26:24])
        3'd0: begin do_read(VEC[i][23:16], w); chk("R2/R8/R13 table read", w, VEC[i][15:0]); end
        3'd1: do_write(2'b01, VEC[i][23:16], VEC[i][15:0]);
        3'd2: do_ext(2'b11);
        default: do_ext(2'b00);
      endcase
    end

    // R12: selected but idle
    sel();
    chk("R12 output off while idle", {15'd0, qoe}, 16'h0000);
    // R1: leading zeros skipped before the start bit
    send(3, 32'd0); hdr(2'b10, 8'h05);
    rd_word(w); desel();
    chk("R1 zeros before start bit", w, 16'h1234);
    chk("R12 output off after deselect", {15'd0, qoe}, 16'h0000);

    // R4: sequential read wraps FFh -> 00h
    do_ext(2'b11);
    do_write(2'b01, 8'hFF, 16'h5A5A);
    do_write(2'b01, 8'h00, 16'h0F0F);
    sel(); hdr(2'b10, 8'hFF); rd_word(w); rd_word(w2); desel();
    chk("R4 first word", w, 16'h5A5A);
    chk("R4 wrapped word, no leading 0", w2, 16'h0F0F);

    // R7: group write wrapping the low two bits
    sel(); hdr(2'b11, 8'h0E);
    send(16, 32'h1111); send(16, 32'h2222); send(16, 32'h3333); send(16, 32'h4444);
    desel(); settle();
    do_read(8'h0E, w); chk("R7 slot 0", w, 16'h1111);
    do_read(8'h0F, w); chk("R7 slot 1", w, 16'h2222);
    do_read(8'h0C, w); chk("R7 slot 2 wrapped", w, 16'h3333);
    do_read(8'h0D, w); chk("R7 slot 3 wrapped", w, 16'h4444);
    do_read(8'h10, w); chk("R7 no carry into bit 2", w, 16'hFFFF);
    sel(); hdr(2'b11, 8'h20); send(16, 32'hAAAA); send(16, 32'hBBBB); desel(); settle();
    do_read(8'h21, w); chk("R7 two-word group", w, 16'hBBBB);
    do_read(8'h22, w); chk("R7 unsent slot kept", w, 16'hFFFF);

    // R6: late and early chip-select fall
    sel(); hdr(2'b01, 8'h30); send(16, 32'h1357); tick(1'b0); desel(); settle();
    do_read(8'h30, w); chk("R6 late fall discards", w, 16'hFFFF);
    sel(); hdr(2'b01, 8'h31); send(10, 32'h3FF); desel(); settle();
    do_read(8'h31, w); chk("R6 early fall discards", w, 16'hFFFF);

    // R9: write-control pin low
    w_pin = 1'b0;
    do_write(2'b01, 8'h32, 16'h0000);
    w_pin = 1'b1;
    do_read(8'h32, w); chk("R9 write-control low discards", w, 16'hFFFF);

    // R11: busy, ignored inputs, ready, cleared by start bit
    sel(); hdr(2'b01, 8'h33); send(16, 32'h2468); desel();
    sel();
    chk("R11 busy shows 0", {14'd0, qoe, q}, 16'h0002);
    hdr(2'b10, 8'h05);
    chk("R11 inputs ignored while busy", {14'd0, qoe, q}, 16'h0002);
    for (int k = 0; k < PROG + 200 && !(qoe && q); k++) @(negedge clk);
    chk("R11 ready shows 1", {14'd0, qoe, q}, 16'h0003);
    tick(1'b1);
    chk("R11 start bit clears ready", {15'd0, qoe}, 16'h0000);
    desel();
    do_read(8'h33, w); chk("R11 word programmed", w, 16'h2468);

    // R14: protect pin high
    pre_pin = 1'b1;
    sel(); hdr(2'b10, 8'h05);
    chk("R14 read refused", {15'd0, qoe}, 16'h0000);
    desel();
    do_write(2'b01, 8'h34, 16'h0000);
    pre_pin = 1'b0;
    do_read(8'h34, w); chk("R14 write refused", w, 16'hFFFF);

    // R10: fill all
    sel(); hdr(2'b00, 8'h40); send(16, 32'hC3C3); desel(); settle();
    do_read(8'h00, w); chk("R10 fill low", w, 16'hC3C3);
    do_read(8'h80, w); chk("R10 fill middle", w, 16'hC3C3);
    do_read(8'hFF, w); chk("R10 fill top", w, 16'hC3C3);

    summary();
    $finish;
  end
endmodule